// File: doc/BRIEF.md
# SMBus Host Register File

This block is the software-facing register set of a PC-style SMBus host controller. It sits on a small byte-wide port window and holds eight registers: status, control, command, target address, two data bytes, a block-data byte and an auxiliary mode register. Every other offset in the window reads as zero and discards writes. Software starts a bus operation by writing the control register with the start bit set. It stops one by writing the kill bit. It learns the outcome by polling status or by taking the level interrupt.

The block does not move bus bits itself. On a start it sends a one-cycle `seq_start` pulse to a separate transaction sequencer. On a kill it sends a one-cycle `seq_kill` pulse. The sequencer reports the result on three flag inputs: done, device error and bus error. Each flag clears busy and sets the matching status bit. When interrupts are disabled, a start does not launch at once. It only marks the controller busy and arms a deferred launch. The launch then fires on the next status read, after that read has returned the busy value.

The register port is synchronous and plain: address, write strobe, read strobe, write data, and read data that is valid in the same cycle as the read strobe. No part of this block carries a data stream, so the block has no valid/ready handshake and no back-pressure.

Top module: `smbh_regfile`

## Requirements
- R1: After reset, status reads 0x00 and the command, address, data and control registers read 0x00. The auxiliary register reads 0x02 when `cfg_force_blk` is high and 0x00 otherwise. `irq` is low.
- R2: The command (0x03), target (0x04), data0 (0x05), data1 (0x06) and block-data (0x07) registers read back the last byte written to them.
- R3: Offsets 0x01, 0x08 and 0x0F read as 0x00, and writes to them change no register.
- R4: The control register (0x02) reads back only bits 4:0 of the last write, with bits 7:5 read as zero. The auxiliary register (0x0D) keeps only bits 1:0.
- R5: Writing status (0x00) clears each of bits 7:1 that is written as one. Bit 0 (busy) is not cleared by a status write.
- R6: A control write with start (bit 6) and interrupt enable (bit 0) both set, kill (bit 1) clear and device error (status bit 2) clear raises `seq_start` for the next cycle and sets busy.
- R7: A control write with start set and interrupt enable clear sets busy and does not raise `seq_start`. The next status read returns the busy value, and `seq_start` follows in the cycle after that read.
- R8: While status bit 2 is set, a start does not raise `seq_start`, and device error stays set.
- R9: A control write with kill set raises `seq_kill` for the next cycle, sets failed (status bit 4), clears busy and cancels an armed deferred start.
- R10: `seq_done` sets status bit 1, `seq_dev_err` sets bit 2 and `seq_bus_err` sets bit 3. Each of them also clears busy.
- R11: `irq` is high exactly when control bit 0 is set and any of status bits 7:1 is set.
- R12: A status bit that the sequencer sets in the same cycle as a status write that clears it ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_force_blk | input | 1 | Forces block-buffer mode on at reset |
| reg_addr | input | AW | Register offset in the window |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the same cycle as the read strobe |
| irq | output | 1 | Level interrupt |
| seq_start | output | 1 | One-cycle launch pulse to the sequencer |
| seq_kill | output | 1 | One-cycle abort pulse to the sequencer |
| seq_proto | output | 3 | Protocol field of the control register |
| seq_last | output | 1 | Last-byte flag |
| seq_pec_en | output | 1 | PEC enable flag |
| seq_cmd | output | 8 | Command byte |
| seq_target | output | 8 | Target address byte (read/write flag in bit 0) |
| seq_data0 | output | 8 | Data byte 0 |
| seq_data1 | output | 8 | Data byte 1 |
| seq_blkdat | output | 8 | Block-data byte |
| seq_aux_mode | output | 2 | Auxiliary mode bits (PEC, block buffer) |
| seq_done | input | 1 | Sequencer finished without error |
| seq_dev_err | input | 1 | Sequencer saw a device error |
| seq_bus_err | input | 1 | Sequencer saw a bus error |

## Verification
The bench tests the deferred start at its boundary. It checks that the status read that triggers the launch still returns busy, and that the launch pulse comes only after that read. A design that launched at the control write, or that cleared busy before the read returned, fails these checks. It also checks that a status write of all ones leaves busy set, and that a kill cancels a pending deferred launch, so that a stale `seq_start` on the next poll is caught. Two further checks cover device error blocking a start, which a design that ignored it would still launch. The last covers a sequencer flag arriving in the same cycle as a software clear, which a design with the wrong priority would lose.

// File: rtl/smbh_pkg.sv
package smbh_pkg;
  localparam int DW = 8;

  // register offsets within the port window
  localparam int OFS_STAT = 'h0;
  localparam int OFS_CTL  = 'h2;
  localparam int OFS_CMD  = 'h3;
  localparam int OFS_TGT  = 'h4;
  localparam int OFS_D0   = 'h5;
  localparam int OFS_D1   = 'h6;
  localparam int OFS_BLK  = 'h7;
  localparam int OFS_AUX  = 'hD;

  // status bit positions
  localparam int ST_BUSY = 0;
  localparam int ST_DONE = 1;
  localparam int ST_DERR = 2;
  localparam int ST_BERR = 3;
  localparam int ST_FAIL = 4;

  // control bit positions
  localparam int CT_IEN   = 0;
  localparam int CT_KILL  = 1;
  localparam int CT_PROTO = 2;
  localparam int CT_LAST  = 5;
  localparam int CT_START = 6;
  localparam int CT_PEC   = 7;

  localparam int AUXW = 2;

  typedef struct packed {
    logic stat;
    logic ctl;
    logic cmd;
    logic tgt;
    logic d0;
    logic d1;
    logic blk;
    logic aux;
  } smbh_sel_t;
endpackage

// File: rtl/smbh_addr_dec.sv
module smbh_addr_dec
  import smbh_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          rd,
  output smbh_sel_t     wsel,
  output logic          stat_rd
);
  always_comb begin
    wsel.stat = wr && (addr == AW'(OFS_STAT));
    wsel.ctl  = wr && (addr == AW'(OFS_CTL));
    wsel.cmd  = wr && (addr == AW'(OFS_CMD));
    wsel.tgt  = wr && (addr == AW'(OFS_TGT));
    wsel.d0   = wr && (addr == AW'(OFS_D0));
    wsel.d1   = wr && (addr == AW'(OFS_D1));
    wsel.blk  = wr && (addr == AW'(OFS_BLK));
    wsel.aux  = wr && (addr == AW'(OFS_AUX));
    stat_rd   = rd && (addr == AW'(OFS_STAT));
  end
endmodule

// File: rtl/smbh_status.sv
module smbh_status #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         w1c_en,
  input  logic [W-1:0] w1c_data,
  input  logic [W-1:0] set_vec,
  input  logic         busy_set,
  input  logic         busy_clr,
  output logic [W-1:0] stat
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_busy
      // busy ignores software clears; a set wins over a clear
      always_ff @(posedge clk) begin
        if (!rst_n)        stat[i] <= 1'b0;
        else if (busy_set) stat[i] <= 1'b1;
        else if (busy_clr) stat[i] <= 1'b0;
      end
    end else begin : g_w1c
      // hardware set wins over a same-cycle write-one-to-clear
      always_ff @(posedge clk) begin
        if (!rst_n) stat[i] <= 1'b0;
        else        stat[i] <= set_vec[i] | (stat[i] & ~(w1c_en & w1c_data[i]));
      end
    end
  end
endmodule

// File: rtl/smbh_launch.sv
module smbh_launch (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic ien_w,
  input  logic kill_w,
  input  logic start_w,
  input  logic stat_rd,
  input  logic dev_err,
  input  logic hw_clear,
  output logic busy_set,
  output logic busy_clr,
  output logic err_again,
  output logic kill_evt,
  output logic go_q,
  output logic kill_q
);
  logic armed_q;
  logic start_evt, now_evt, defer_fire, run, go, arm_set;

  always_comb begin
    start_evt  = ctl_wr && start_w;
    kill_evt   = ctl_wr && kill_w;
    now_evt    = start_evt && ien_w;
    defer_fire = stat_rd && armed_q;
    run        = now_evt || defer_fire;
    go         = run && !dev_err && !kill_evt;
    err_again  = run && dev_err && !kill_evt;
    arm_set    = start_evt && !ien_w && !kill_evt;
    busy_set   = (arm_set || go) && !kill_evt;
    busy_clr   = kill_evt || defer_fire || hw_clear;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      go_q    <= 1'b0;
      kill_q  <= 1'b0;
    end else begin
      go_q   <= go;
      kill_q <= kill_evt;
      if (kill_evt || now_evt) armed_q <= 1'b0;
      else if (arm_set)        armed_q <= 1'b1;
      else if (defer_fire)     armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/smbh_regfile.sv
module smbh_regfile
  import smbh_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_force_blk,
  input  logic [AW-1:0]   reg_addr,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            irq,
  output logic            seq_start,
  output logic            seq_kill,
  output logic [2:0]      seq_proto,
  output logic            seq_last,
  output logic            seq_pec_en,
  output logic [DW-1:0]   seq_cmd,
  output logic [DW-1:0]   seq_target,
  output logic [DW-1:0]   seq_data0,
  output logic [DW-1:0]   seq_data1,
  output logic [DW-1:0]   seq_blkdat,
  output logic [AUXW-1:0] seq_aux_mode,
  input  logic            seq_done,
  input  logic            seq_dev_err,
  input  logic            seq_bus_err
);
  smbh_sel_t       wsel;
  logic            stat_rd;
  logic [DW-1:0]   stat_q;
  logic [DW-1:0]   set_vec;
  logic            busy_set, busy_clr, err_again, kill_evt;
  logic            ien_q, killb_q, last_q, pec_q;
  logic [2:0]      proto_q;
  logic [DW-1:0]   cmd_q, tgt_q, d0_q, d1_q, blk_q;
  logic [AUXW-1:0] aux_q;

  smbh_addr_dec #(.AW(AW)) u_dec (
    .addr(reg_addr), .wr(reg_wr), .rd(reg_rd), .wsel(wsel), .stat_rd(stat_rd)
  );

  smbh_launch u_launch (
    .clk(clk), .rst_n(rst_n), .ctl_wr(wsel.ctl),
    .ien_w(reg_wdata[CT_IEN]), .kill_w(reg_wdata[CT_KILL]),
    .start_w(reg_wdata[CT_START]), .stat_rd(stat_rd),
    .dev_err(stat_q[ST_DERR]),
    .hw_clear(seq_done || seq_dev_err || seq_bus_err),
    .busy_set(busy_set), .busy_clr(busy_clr), .err_again(err_again),
    .kill_evt(kill_evt), .go_q(seq_start), .kill_q(seq_kill)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[ST_DONE] = seq_done;
    set_vec[ST_DERR] = seq_dev_err || err_again;
    set_vec[ST_BERR] = seq_bus_err;
    set_vec[ST_FAIL] = kill_evt;
  end

  smbh_status #(.W(DW)) u_stat (
    .clk(clk), .rst_n(rst_n), .w1c_en(wsel.stat), .w1c_data(reg_wdata),
    .set_vec(set_vec), .busy_set(busy_set), .busy_clr(busy_clr), .stat(stat_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien_q   <= 1'b0;
      killb_q <= 1'b0;
      proto_q <= '0;
      last_q  <= 1'b0;
      pec_q   <= 1'b0;
      cmd_q   <= '0;
      tgt_q   <= '0;
      d0_q    <= '0;
      d1_q    <= '0;
      blk_q   <= '0;
      aux_q   <= {cfg_force_blk, 1'b0};
    end else begin
      if (wsel.ctl) begin
        ien_q   <= reg_wdata[CT_IEN];
        killb_q <= reg_wdata[CT_KILL];
        proto_q <= reg_wdata[CT_PROTO +: 3];
        last_q  <= reg_wdata[CT_LAST];
        pec_q   <= reg_wdata[CT_PEC];
      end
      if (wsel.cmd) cmd_q <= reg_wdata;
      if (wsel.tgt) tgt_q <= reg_wdata;
      if (wsel.d0)  d0_q  <= reg_wdata;
      if (wsel.d1)  d1_q  <= reg_wdata;
      if (wsel.blk) blk_q <= reg_wdata;
      if (wsel.aux) aux_q <= reg_wdata[AUXW-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_addr)
        AW'(OFS_STAT): reg_rdata = stat_q;
        AW'(OFS_CTL):  reg_rdata = {3'b000, proto_q, killb_q, ien_q};
        AW'(OFS_CMD):  reg_rdata = cmd_q;
        AW'(OFS_TGT):  reg_rdata = tgt_q;
        AW'(OFS_D0):   reg_rdata = d0_q;
        AW'(OFS_D1):   reg_rdata = d1_q;
        AW'(OFS_BLK):  reg_rdata = blk_q;
        AW'(OFS_AUX):  reg_rdata = {{(DW-AUXW){1'b0}}, aux_q};
        default:       reg_rdata = '0;
      endcase
    end
  end

  assign irq          = ien_q && (|stat_q[DW-1:1]);
  assign seq_proto    = proto_q;
  assign seq_last     = last_q;
  assign seq_pec_en   = pec_q;
  assign seq_cmd      = cmd_q;
  assign seq_target   = tgt_q;
  assign seq_data0    = d0_q;
  assign seq_data1    = d1_q;
  assign seq_blkdat   = blk_q;
  assign seq_aux_mode = aux_q;
endmodule

// File: rtl/smbh_chk.sv
module smbh_chk
  import smbh_pkg::*;
#(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] reg_addr,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [DW-1:0] reg_wdata,
  input logic [DW-1:0] reg_rdata,
  input logic [DW-1:0] stat,
  input logic          seq_start,
  input logic          seq_kill,
  input logic          seq_done,
  input logic          seq_dev_err,
  input logic          seq_bus_err
);
  logic ctl_w, hw_flag;
  assign ctl_w   = reg_wr && (reg_addr == AW'(OFS_CTL));
  assign hw_flag = seq_done || seq_dev_err || seq_bus_err;

  // R6
  start_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_w && reg_wdata[CT_START] && reg_wdata[CT_IEN] && !reg_wdata[CT_KILL] && !stat[ST_DERR])
      |=> (seq_start && stat[ST_BUSY]));

  // R7
  start_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_w && reg_wdata[CT_START] && !reg_wdata[CT_IEN] && !reg_wdata[CT_KILL])
      |=> (!seq_start && stat[ST_BUSY]));

  // R8
  deverr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_w && reg_wdata[CT_START] && reg_wdata[CT_IEN] && stat[ST_DERR])
      |=> (!seq_start && stat[ST_DERR]));

  // R9
  kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_w && reg_wdata[CT_KILL]) |=> (seq_kill && stat[ST_FAIL] && !stat[ST_BUSY]));

  // R5
  busy_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr == AW'(OFS_STAT)) && stat[ST_BUSY] && !hw_flag)
      |=> stat[ST_BUSY]);

  // R10
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && !ctl_w && !reg_rd) |=> (stat[ST_DONE] && !stat[ST_BUSY]));

  // R4
  ctl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && (reg_addr == AW'(OFS_CTL))) |-> (reg_rdata[7:5] == 3'b000));
endmodule

bind smbh_regfile smbh_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .stat(stat_q), .seq_start(seq_start), .seq_kill(seq_kill),
  .seq_done(seq_done), .seq_dev_err(seq_dev_err), .seq_bus_err(seq_bus_err)
);

// File: tb/sim_smbh_regfile.sv
module sim_smbh_regfile;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int NVEC = 11;
  // {offset, write value, expected readback}
  localparam logic [23:0] VEC [NVEC] = '{
    24'h03_5A_5A, 24'h04_A3_A3, 24'h05_11_11, 24'h06_EE_EE, 24'h07_7F_7F,
    24'h0D_FF_03, 24'h02_BC_1C, 24'h02_A5_05, 24'h01_FF_00, 24'h08_FF_00,
    24'h0F_55_00
  };

  logic clk = 0, rst_n = 0, cfg_force_blk = 1;
  logic [AW-1:0] reg_addr = '0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic irq, seq_start, seq_kill, seq_last, seq_pec_en;
  logic [2:0] seq_proto;
  logic [7:0] seq_cmd, seq_target, seq_data0, seq_data1, seq_blkdat;
  logic [1:0] seq_aux_mode;
  logic seq_done = 0, seq_dev_err = 0, seq_bus_err = 0;
  int checks = 0, errors = 0;
  logic [7:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  smbh_regfile #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_force_blk(cfg_force_blk),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .seq_start(seq_start), .seq_kill(seq_kill), .seq_proto(seq_proto),
    .seq_last(seq_last), .seq_pec_en(seq_pec_en), .seq_cmd(seq_cmd),
    .seq_target(seq_target), .seq_data0(seq_data0), .seq_data1(seq_data1),
    .seq_blkdat(seq_blkdat), .seq_aux_mode(seq_aux_mode),
    .seq_done(seq_done), .seq_dev_err(seq_dev_err), .seq_bus_err(seq_bus_err)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    reg_addr = a[AW-1:0]; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a[AW-1:0]; reg_rd = 1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic flag(logic dn, logic de, logic be);
    @(negedge clk);
    seq_done = dn; seq_dev_err = de; seq_bus_err = be;
    @(negedge clk);
    seq_done = 0; seq_dev_err = 0; seq_bus_err = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(8'h00, rv); check("R1 status", rv, 8'h00);
    rd(8'h0D, rv); check("R1 aux forced", rv, 8'h02);
    rd(8'h03, rv); check("R1 cmd", rv, 8'h00);
    rd(8'h02, rv); check("R1 ctl", rv, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);

    // R2 R3 R4 table walk
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][23:16], VEC[i][15:8]);
      rd(VEC[i][23:16], rv);
      check("R2/R3/R4 table", rv, VEC[i][7:0]);
    end
    // R3 unmapped writes left mapped registers alone
    rd(8'h03, rv); check("R3 cmd kept", rv, 8'h5A);
    rd(8'h07, rv); check("R3 blk kept", rv, 8'h7F);

    // R6 immediate start
    wr(8'h02, 8'h41);
    check("R6 seq_start", {7'b0, seq_start}, 8'h01);
    rd(8'h02, rv); check("R4 start reads zero", rv, 8'h01);
    rd(8'h00, rv); check("R6 busy", rv, 8'h01);
    check("R11 irq low on busy only", {7'b0, irq}, 8'h00);
    // R10 done
    flag(1, 0, 0);
    rd(8'h00, rv); check("R10 done", rv, 8'h02);
    check("R11 irq high", {7'b0, irq}, 8'h01);
    wr(8'h00, 8'hFF);
    rd(8'h00, rv); check("R5 clear all", rv, 8'h00);
    check("R11 irq after clear", {7'b0, irq}, 8'h00);
    // R5 busy survives write of ones
    wr(8'h02, 8'h41);
    wr(8'h00, 8'hFF);
    rd(8'h00, rv); check("R5 busy kept", rv, 8'h01);
    flag(0, 0, 1);
    rd(8'h00, rv); check("R10 bus err", rv, 8'h08);
    wr(8'h00, 8'h08);

    // R7 deferred start
    wr(8'h02, 8'h40);
    check("R7 no pulse at write", {7'b0, seq_start}, 8'h00);
    rd(8'h00, rv); check("R7 read sees busy", rv, 8'h01);
    check("R7 pulse after read", {7'b0, seq_start}, 8'h01);
    rd(8'h00, rv); check("R7 busy while running", rv, 8'h01);
    check("R7 single pulse", {7'b0, seq_start}, 8'h00);
    flag(1, 0, 0);
    check("R11 irq masked", {7'b0, irq}, 8'h00);
    wr(8'h00, 8'h02);

    // R8 device error blocks start
    flag(0, 1, 0);
    wr(8'h02, 8'h41);
    check("R8 no pulse", {7'b0, seq_start}, 8'h00);
    rd(8'h00, rv); check("R8 dev err kept", rv, 8'h04);
    wr(8'h00, 8'h04);

    // R9 kill cancels deferred start
    wr(8'h02, 8'h40);
    wr(8'h02, 8'h02);
    check("R9 kill pulse", {7'b0, seq_kill}, 8'h01);
    rd(8'h00, rv); check("R9 failed no busy", rv, 8'h10);
    check("R9 deferred cancelled", {7'b0, seq_start}, 8'h00);
    wr(8'h00, 8'h10);

    // R12 set wins over same-cycle clear
    flag(1, 0, 0);
    @(negedge clk);
    reg_addr = '0; reg_wdata = 8'h02; reg_wr = 1; seq_done = 1;
    @(negedge clk);
    reg_wr = 0; seq_done = 0;
    rd(8'h00, rv); check("R12 set wins", rv, 8'h02);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule